// File: doc/BRIEF.md
# User-Level Counter Access Filter

This block decides, for one access at a time, what the least-privileged software level may do to one performance counter and to the control bits that belong to it: the counter-enable set/clear bits and the overflow set/clear bits. A 64-bit control word holds one permission bit per general event counter, plus one for the cycle counter and one for the instruction counter. Combined with the user-enable mode bit and three per-class write-mode bits, that word gives the verdict for the selected counter.

The verdict is one of four codes. "No override" means the filter stands aside and the older enable-based rules downstream apply. The other three are read-as-zero/write-ignored, read-only and read/write. A second output tells the counter-zeroing logic to drop a user write to that counter's zeroing bit. The filter stands aside when the next-higher privilege level runs in 32-bit mode, when the user-enable mode bit is clear, or when the access already raises an exception.

The control word is a register written by privileged software. An event-counter bit whose index is at or above the number of accessible counters reads as zero and cannot be written. Everything else in the block is combinational, from the stored word and the live inputs to the verdict.

Top module: `ucnt_access_filter`

## Requirements
- R1: After reset the control word reads as all zeros (the default reset value), so every counter selected with the filter active gets the read-as-zero verdict.
- R2: A write stores the written value in every writable bit. Writable bits are the event bits below the accessible count, the cycle bit at position 31 and the instruction bit at position 32. Bits 63:33 always read zero and keep no written value.
- R3: When the instruction counter is not built (HAS_ICNT=0), bit 32 reads zero, ignores writes, and an instruction-counter access that is not bypassed gets read-as-zero.
- R4: Event bit i (positions 30:0) reads zero and ignores writes while i is at or above num_acc. An event access with sel_idx at or above num_acc gets read-as-zero when not bypassed.
- R5: When lvl_hi_32 is 1, ctl_uen is 0 or acc_exc is 1, the verdict is no-override (code 2'b00) and zero_wr_blk is 0, whatever the control word holds.
- R6: When not bypassed and the selected counter's effective permission bit is 0, the verdict is read-as-zero/write-ignored (code 2'b01).
- R7: When not bypassed and the permission bit is 1, the verdict is read-only (2'b10) if the class's write-mode bit is 0 and read/write (2'b11) if it is 1. The mode bit is ctl_er for event counters, ctl_cr for the cycle counter and ctl_ir for the instruction counter.
- R8: sel_kind selects the counter class: 2'b00 event counter sel_idx, 2'b01 cycle counter, 2'b10 instruction counter. Code 2'b11, and an event index at or above 31, give read-as-zero when not bypassed.
- R9: A control-word write changes cw_rd_data and the verdict from the clock edge that captures it. Before that edge both still reflect the old word, and with cw_wr_en low the word holds.
- R10: zero_wr_blk is 1 exactly when the verdict is read-as-zero/write-ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_wr_en | input | 1 | Control-word write strobe |
| cw_wr_data | input | 64 | Control-word write value |
| cw_rd_data | output | 64 | Control-word read value with non-writable bits shown as zero |
| num_acc | input | 5 | Number of event counters accessible |
| lvl_hi_32 | input | 1 | Next-higher privilege level runs in 32-bit mode |
| ctl_uen | input | 1 | User-enable mode bit turning per-counter filtering on |
| ctl_cr | input | 1 | Write mode for the cycle counter |
| ctl_er | input | 1 | Write mode for the event counters |
| ctl_ir | input | 1 | Write mode for the instruction counter |
| acc_exc | input | 1 | The access already raises an exception |
| sel_kind | input | 2 | Counter class selector |
| sel_idx | input | 5 | Event counter index |
| verdict | output | 2 | 00 no override, 01 read-as-zero, 10 read-only, 11 read/write |
| zero_wr_blk | output | 1 | Drop the user write to the selected counter's zeroing bit |

## Verification
On every cycle the assertions check the following. The bypass conditions force the no-override code. The zeroing-write block tracks the read-as-zero verdict in both directions. Reserved class codes and out-of-range event indices are refused. The cycle counter takes its write mode from its own bit. A write lands in the writable bits and leaves the fenced bits alone, and the word holds without a write. Only the bench's scenarios show the rest: writes made while num_acc is small stay lost after it grows, the build without the instruction counter hides bit 32, and the verdict switches on the edge after a write and not before.

// File: rtl/ucaf_pkg.sv
package ucaf_pkg;

  typedef enum logic [1:0] {
    VD_PASS   = 2'b00,
    VD_RAZWI  = 2'b01,
    VD_RDONLY = 2'b10,
    VD_RDWR   = 2'b11
  } verdict_e;

  typedef enum logic [1:0] {
    SK_EVENT = 2'b00,
    SK_CYCLE = 2'b01,
    SK_INSTR = 2'b10,
    SK_RSVD  = 2'b11
  } sel_kind_e;

  // Mask with the n lowest bits set.
  function automatic logic [63:0] low_ones(input int unsigned n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < n);
    return m;
  endfunction

  // Bits that can ever be writable: event bits, cycle bit, optional instruction bit.
  function automatic logic [63:0] build_mask(input int unsigned n_evt, input bit has_icnt);
    logic [63:0] m;
    m = low_ones(n_evt);
    m[n_evt] = 1'b1;
    if (has_icnt) m[n_evt + 1] = 1'b1;
    return m;
  endfunction

  // Bits writable right now, given the accessible event count.
  function automatic logic [63:0] live_mask(input int unsigned n_evt, input bit has_icnt,
                                            input int unsigned n_acc);
    logic [63:0] m;
    m = low_ones((n_acc < n_evt) ? n_acc : n_evt);
    m[n_evt] = 1'b1;
    if (has_icnt) m[n_evt + 1] = 1'b1;
    return m;
  endfunction

  function automatic verdict_e grant(input logic en, input logic wr_ok);
    if (!en) return VD_RAZWI;
    return wr_ok ? VD_RDWR : VD_RDONLY;
  endfunction

endpackage

// File: rtl/ucaf_ctrl_reg.sv
module ucaf_ctrl_reg #(
  parameter int              CTRL_W   = 64,
  parameter int              NUM_EVT  = 31,
  parameter bit              HAS_ICNT = 1'b1,
  parameter int              IDX_W    = 5,
  parameter logic [CTRL_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  num_acc,
  output logic [CTRL_W-1:0] q_vis
);
  import ucaf_pkg::*;

  localparam logic [63:0]       BUILD64 = build_mask(NUM_EVT, HAS_ICNT);
  localparam logic [CTRL_W-1:0] BUILD   = BUILD64[CTRL_W-1:0];

  logic [CTRL_W-1:0] q;
  logic [CTRL_W-1:0] legal;
  logic [CTRL_W-1:0] q_next;
  logic [63:0]       legal64;

  assign legal64 = live_mask(NUM_EVT, HAS_ICNT, 32'(num_acc));
  assign legal   = legal64[CTRL_W-1:0];
  assign q_next  = (q & ~legal) | (wr_data & legal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL & BUILD;
    else if (wr_en) q <= q_next;
  end

  assign q_vis = q & legal;

  AST_WR_LANDS:  assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(wr_data)) & $past(legal)) == '0)); // R2
  AST_WR_FENCED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(legal)) == '0)); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R9

endmodule

// File: rtl/ucaf_bit_pick.sv
module ucaf_bit_pick #(
  parameter int NUM_EVT  = 31,
  parameter bit HAS_ICNT = 1'b1,
  parameter int IDX_W    = 5,
  localparam int PICK_W  = NUM_EVT + 2
) (
  input  logic [PICK_W-1:0] perm,
  input  logic [1:0]        kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic              mode_cr,
  input  logic              mode_er,
  input  logic              mode_ir,
  output logic              en_bit,
  output logic              wr_ok
);
  import ucaf_pkg::*;

  localparam int CYC_POS  = NUM_EVT;
  localparam int ICNT_POS = NUM_EVT + 1;

  logic icnt_bit;
  logic evt_bit;

  generate
    if (HAS_ICNT) begin : g_icnt
      assign icnt_bit = perm[ICNT_POS];
    end else begin : g_noicnt
      assign icnt_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    evt_bit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++)
      if (32'(idx) == i) evt_bit = perm[i];
  end

  always_comb begin
    unique case (sel_kind_e'(kind))
      SK_EVENT: begin en_bit = evt_bit;       wr_ok = mode_er; end
      SK_CYCLE: begin en_bit = perm[CYC_POS]; wr_ok = mode_cr; end
      SK_INSTR: begin en_bit = icnt_bit;      wr_ok = mode_ir; end
      default:  begin en_bit = 1'b0;          wr_ok = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/ucaf_verdict.sv
module ucaf_verdict (
  input  logic       lvl_hi_32,
  input  logic       uen,
  input  logic       exc,
  input  logic       en_bit,
  input  logic       wr_ok,
  output logic       bypass,
  output logic [1:0] verdict,
  output logic       zero_blk
);
  import ucaf_pkg::*;

  verdict_e vd;

  assign bypass   = lvl_hi_32 | ~uen | exc;
  assign vd       = bypass ? VD_PASS : grant(en_bit, wr_ok);
  assign verdict  = vd;
  assign zero_blk = ~bypass & ~en_bit;

endmodule

// File: rtl/ucnt_access_filter.sv
module ucnt_access_filter #(
  parameter int              CTRL_W   = 64,
  parameter int              NUM_EVT  = 31,
  parameter bit              HAS_ICNT = 1'b1,
  parameter logic [CTRL_W-1:0] RST_VAL = '0,
  localparam int             IDX_W    = $clog2(NUM_EVT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr_en,
  input  logic [CTRL_W-1:0] cw_wr_data,
  output logic [CTRL_W-1:0] cw_rd_data,
  input  logic [IDX_W-1:0]  num_acc,
  input  logic              lvl_hi_32,
  input  logic              ctl_uen,
  input  logic              ctl_cr,
  input  logic              ctl_er,
  input  logic              ctl_ir,
  input  logic              acc_exc,
  input  logic [1:0]        sel_kind,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic [1:0]        verdict,
  output logic              zero_wr_blk
);
  import ucaf_pkg::*;

  localparam int CYC_POS = NUM_EVT;
  localparam int PICK_W  = NUM_EVT + 2;

  logic en_bit;
  logic wr_ok;
  logic bypass;

  ucaf_ctrl_reg #(
    .CTRL_W(CTRL_W), .NUM_EVT(NUM_EVT), .HAS_ICNT(HAS_ICNT),
    .IDX_W(IDX_W), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cw_wr_en), .wr_data(cw_wr_data),
    .num_acc(num_acc), .q_vis(cw_rd_data)
  );

  ucaf_bit_pick #(
    .NUM_EVT(NUM_EVT), .HAS_ICNT(HAS_ICNT), .IDX_W(IDX_W)
  ) u_pick (
    .perm(cw_rd_data[PICK_W-1:0]), .kind(sel_kind), .idx(sel_idx),
    .mode_cr(ctl_cr), .mode_er(ctl_er), .mode_ir(ctl_ir),
    .en_bit(en_bit), .wr_ok(wr_ok)
  );

  ucaf_verdict u_vd (
    .lvl_hi_32(lvl_hi_32), .uen(ctl_uen), .exc(acc_exc),
    .en_bit(en_bit), .wr_ok(wr_ok),
    .bypass(bypass), .verdict(verdict), .zero_blk(zero_wr_blk)
  );

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hi_32 || !ctl_uen || acc_exc) |-> (verdict == VD_PASS && !zero_wr_blk)); // R5
  AST_BLK_IS_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr_blk |-> (verdict == VD_RAZWI)); // R10
  AST_RAZ_IS_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_RAZWI) |-> zero_wr_blk); // R10
  AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && sel_kind == SK_RSVD) |-> (verdict == VD_RAZWI)); // R8
  AST_OOR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && sel_kind == SK_EVENT && sel_idx >= num_acc) |-> (verdict == VD_RAZWI)); // R4
  AST_CYC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && sel_kind == SK_CYCLE && cw_rd_data[CYC_POS])
      |-> (verdict == (ctl_cr ? VD_RDWR : VD_RDONLY))); // R7

endmodule

// File: tb/ucnt_access_filter_tb.sv
module ucnt_access_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [63:0] wd = '0;
  logic [4:0]  na = 5'd31;
  logic        h32 = 1'b0, uen = 1'b0, cr = 1'b0, er = 1'b0, ir = 1'b0, exc = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [4:0]  idx = '0;
  logic [63:0] rd_a, rd_b;
  logic [1:0]  vd_a, vd_b;
  logic        blk_a, blk_b;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m_a = '0, m_b = '0;

  always #10 clk = ~clk;

  ucnt_access_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cw_wr_en(wr), .cw_wr_data(wd), .cw_rd_data(rd_a),
    .num_acc(na), .lvl_hi_32(h32), .ctl_uen(uen), .ctl_cr(cr), .ctl_er(er),
    .ctl_ir(ir), .acc_exc(exc), .sel_kind(kind), .sel_idx(idx),
    .verdict(vd_a), .zero_wr_blk(blk_a));

  ucnt_access_filter #(.HAS_ICNT(1'b0)) u_dut_noicnt (
    .clk(clk), .rst_n(rst_n), .cw_wr_en(wr), .cw_wr_data(wd), .cw_rd_data(rd_b),
    .num_acc(na), .lvl_hi_32(h32), .ctl_uen(uen), .ctl_cr(cr), .ctl_er(er),
    .ctl_ir(ir), .acc_exc(exc), .sel_kind(kind), .sel_idx(idx),
    .verdict(vd_b), .zero_wr_blk(blk_b));

  function automatic logic [63:0] vis(int n, bit hasi);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++)
      m[i] = (i < 31 && i < n) || i == 31 || (i == 32 && hasi);
    return m;
  endfunction

  function automatic int exp_vd(logic [63:0] m, bit hasi);
    bit en = 0, mode = 0;
    if (h32 || !uen || exc) return 0;
    if (kind == 0) begin en = (idx < 31 && idx < na) ? m[idx] : 1'b0; mode = er; end
    else if (kind == 1) begin en = m[31]; mode = cr; end
    else if (kind == 2) begin en = hasi && m[32]; mode = ir; end
    if (!en) return 1;
    return mode ? 3 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_a <= '0; m_b <= '0; end
    else if (wr) begin
      m_a <= (m_a & ~vis(na, 1)) | (wd & vis(na, 1));
      m_b <= (m_b & ~vis(na, 0)) | (wd & vis(na, 0));
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs were applied at the negedge; compare 1 ns later, then wait for the next negedge.
  task automatic tick(string tag);
    int ea, eb;
    #1;
    ea = exp_vd(m_a, 1);
    eb = exp_vd(m_b, 0);
    chk({tag, " rd"}, rd_a, m_a & vis(na, 1));
    chk({tag, " verdict"}, 64'(vd_a), 64'(ea));
    chk("R10 blk", 64'(blk_a), 64'(ea == 1));
    chk("R3 rd", rd_b, m_b & vis(na, 0));
    chk("R3 verdict", 64'(vd_b), 64'(eb));
    chk("R10 blk", 64'(blk_b), 64'(eb == 1));
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    uen = 1; kind = 2'b01;
    tick("R1");                              // during reset
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin kind = 2'(k); tick("R1"); end

    // R2: full write, reserved high bits stay zero
    na = 31; wr = 1; wd = '1; tick("R2");
    wr = 0; kind = 2'b10; ir = 1; tick("R2");
    wr = 1; wd = 64'hA5A5_5A5A_C3C3_3C3C; tick("R2");
    wr = 0; tick("R2");

    // R4: narrow accessible range fences writes
    wr = 1; wd = '0; tick("R4");
    na = 4; wd = '1; tick("R4");
    wr = 0; tick("R4");
    na = 31;
    for (int i = 0; i < 8; i++) begin kind = 2'b00; idx = 5'(i); er = i[0]; tick("R4"); end
    na = 10; idx = 12; tick("R4");

    // R5: each bypass reason alone
    na = 31; wr = 1; wd = '1; tick("R5");
    wr = 0; kind = 2'b01;
    h32 = 1; tick("R5"); h32 = 0;
    uen = 0; tick("R5"); uen = 1;
    exc = 1; tick("R5"); exc = 0;
    tick("R7");

    // R6/R7/R8: sweep classes, indices and modes with a patterned word
    wr = 1; wd = 64'h0000_0001_5555_5555; tick("R6");
    wr = 0;
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < 32; i += 3) begin
          kind = 2'(k); idx = 5'(i); cr = m[0]; er = ~m[0]; ir = m[0];
          tick(k == 3 ? "R8" : "R7");
        end
    kind = 2'b00; idx = 31; tick("R8");

    // R9: verdict changes only after the capturing edge
    wr = 1; wd = '0; kind = 2'b01; cr = 1; tick("R9");
    wr = 0; tick("R9");
    wr = 1; wd = 64'h8000_0000; tick("R9");
    wr = 0; tick("R9");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      wr = ($urandom % 4) == 0; wd = {$urandom, $urandom};
      na = 5'($urandom % 32); h32 = ($urandom % 8) == 0; uen = ($urandom % 6) != 0;
      exc = ($urandom % 8) == 0; cr = 1'($urandom); er = 1'($urandom); ir = 1'($urandom);
      kind = 2'($urandom); idx = 5'($urandom);
      tick("R6");
    end

    done = 1;
    summary();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      summary();
    end
  end

endmodule